// File: doc/BRIEF.md
# Cascadable Pipelined Signed Multiplier

This block forms the full-width signed product of two two's complement operands, 18 bits each by default, giving a 36-bit signed result. It has three optional pipeline registers: one on the first operand, one on the second operand and one on the product. Each is switched in or out at elaboration time. Every register present has its own clock enable and its own synchronous reset, and the reset wins over the enable.

The second operand comes from one of two places, chosen by a parameter: the block's own second-operand port, or a chain input fed from a neighbouring multiplier. The value that actually reaches the second multiplier input is driven on a chain output, so that several multipliers can share one coefficient stream. Each of the clock, the three enables and the three resets can be set to active-low at elaboration time.

Top module: `mul_casc`

## Requirements
- R1: The product is the exact signed product of the two operand values with full sign extension; -131072 times -131072 gives +17179869184, and 131071 times -131072 gives -17179738112.
- R2: With B_SRC = B_FROM_PORT the second operand is taken from `b_op` and `b_casc_in` has no effect. With B_SRC = B_FROM_CHAIN it is taken from `b_casc_in` and `b_op` has no effect.
- R3: `b_casc_out` equals the value applied to the second multiplier input. Without the B register it follows the selected source combinationally. With the B register it is that register's content.
- R4: A register that is present loads its input on the active clock edge when its enable is active and its reset is inactive. It holds its value when its enable is inactive.
- R5: A register whose reset is active on an active clock edge becomes zero, whatever the state of its enable.
- R6: With no registers present, `prod` and `b_casc_out` follow the inputs combinationally.
- R7: With the product register present, `prod` changes only on an active clock edge. It takes the multiplier result present just before that edge, under `ce_p` and `rst_p`.
- R8: Every register holds zero from power-up until its first load.
- R9: Setting an INV_* parameter makes the matching control active-low. For the clock, it makes the registers load on the falling edge of `clk`.
- R10: With input registers present and no product register, `prod` changes on the edge that updates those registers, and is zero one edge after an A or B reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; active edge set by INV_CLK |
| a_op | input | AW | First operand, signed |
| b_op | input | BW | Second operand from the local port, signed |
| b_casc_in | input | BW | Second operand from the chain, signed |
| ce_a | input | 1 | Enable of the A register |
| rst_a | input | 1 | Synchronous reset of the A register |
| ce_b | input | 1 | Enable of the B register |
| rst_b | input | 1 | Synchronous reset of the B register |
| ce_p | input | 1 | Enable of the product register |
| rst_p | input | 1 | Synchronous reset of the product register |
| prod | output | AW+BW | Signed product |
| b_casc_out | output | BW | Second operand as applied, to the chain |

## Verification
A stale or wrongly reset B register shows on `b_casc_out` on the very next edge, and on `prod` in the same cycle when no product register follows it. A wrong A register shows on `prod` at the edge after the bad load, or one edge later behind the product register. A wrong product register shows at once at the next edge. Every register option is paired with both operand sources, so a wrong source or an ignored enable shows up as a mismatch against the latency-aware model at the first cycle where the two operand ports differ.

// File: rtl/mulc_pkg.sv
package mulc_pkg;
  typedef enum logic {
    B_FROM_PORT  = 1'b0,
    B_FROM_CHAIN = 1'b1
  } bsrc_e;
endpackage

// File: rtl/mulc_stage.sv
// Optional pipeline register: synchronous reset has priority over enable.
module mulc_stage #(
  parameter int W = 18,
  parameter bit EN = 1'b1
) (
  input  logic         clk,
  input  logic         ce,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (EN) begin : g_reg
      logic [W-1:0] q_r = '0;
      always_ff @(posedge clk) begin
        if (rst)     q_r <= '0;
        else if (ce) q_r <= d;
      end
      assign q = q_r;
    end else begin : g_wire
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/mulc_bsel.sv
// Second-operand source selection, fixed at elaboration.
module mulc_bsel #(
  parameter int W = 18,
  parameter mulc_pkg::bsrc_e SRC = mulc_pkg::B_FROM_PORT
) (
  input  logic [W-1:0] from_port,
  input  logic [W-1:0] from_chain,
  output logic [W-1:0] sel
);
  generate
    if (SRC == mulc_pkg::B_FROM_CHAIN) begin : g_chain
      assign sel = from_chain;
    end else begin : g_port
      assign sel = from_port;
    end
  endgenerate
endmodule

// File: rtl/mulc_mult.sv
// Full-width signed multiplier.
module mulc_mult #(
  parameter int AW = 18,
  parameter int BW = 18,
  localparam int PW = AW + BW
) (
  input  logic signed [AW-1:0] a,
  input  logic signed [BW-1:0] b,
  output logic signed [PW-1:0] p
);
  logic signed [PW-1:0] a_x;
  logic signed [PW-1:0] b_x;
  assign a_x = PW'(a);
  assign b_x = PW'(b);
  assign p   = a_x * b_x;
endmodule

// File: rtl/mul_casc.sv
module mul_casc #(
  parameter int AW = 18,
  parameter int BW = 18,
  parameter bit A_REG = 1'b1,
  parameter bit B_REG = 1'b1,
  parameter bit P_REG = 1'b1,
  parameter mulc_pkg::bsrc_e B_SRC = mulc_pkg::B_FROM_PORT,
  parameter bit INV_CLK   = 1'b0,
  parameter bit INV_CE_A  = 1'b0,
  parameter bit INV_RST_A = 1'b0,
  parameter bit INV_CE_B  = 1'b0,
  parameter bit INV_RST_B = 1'b0,
  parameter bit INV_CE_P  = 1'b0,
  parameter bit INV_RST_P = 1'b0,
  localparam int PW = AW + BW
) (
  input  logic          clk,
  input  logic [AW-1:0] a_op,
  input  logic [BW-1:0] b_op,
  input  logic [BW-1:0] b_casc_in,
  input  logic          ce_a,
  input  logic          rst_a,
  input  logic          ce_b,
  input  logic          rst_b,
  input  logic          ce_p,
  input  logic          rst_p,
  output logic [PW-1:0] prod,
  output logic [BW-1:0] b_casc_out
);
  // Polarity-corrected controls
  logic clk_e;
  logic ce_a_e, rst_a_e, ce_b_e, rst_b_e, ce_p_e, rst_p_e;
  assign clk_e   = clk   ^ INV_CLK;
  assign ce_a_e  = ce_a  ^ INV_CE_A;
  assign rst_a_e = rst_a ^ INV_RST_A;
  assign ce_b_e  = ce_b  ^ INV_CE_B;
  assign rst_b_e = rst_b ^ INV_RST_B;
  assign ce_p_e  = ce_p  ^ INV_CE_P;
  assign rst_p_e = rst_p ^ INV_RST_P;

  logic [BW-1:0] b_pick;
  logic [AW-1:0] a_st;
  logic [BW-1:0] b_st;
  logic [PW-1:0] p_raw;

  mulc_bsel #(.W(BW), .SRC(B_SRC)) u_bsel (
    .from_port (b_op),
    .from_chain(b_casc_in),
    .sel       (b_pick)
  );

  mulc_stage #(.W(AW), .EN(A_REG)) u_areg (
    .clk(clk_e), .ce(ce_a_e), .rst(rst_a_e), .d(a_op), .q(a_st)
  );

  mulc_stage #(.W(BW), .EN(B_REG)) u_breg (
    .clk(clk_e), .ce(ce_b_e), .rst(rst_b_e), .d(b_pick), .q(b_st)
  );

  mulc_mult #(.AW(AW), .BW(BW)) u_mult (
    .a(a_st), .b(b_st), .p(p_raw)
  );

  mulc_stage #(.W(PW), .EN(P_REG)) u_preg (
    .clk(clk_e), .ce(ce_p_e), .rst(rst_p_e), .d(p_raw), .q(prod)
  );

  assign b_casc_out = b_st;
endmodule

// File: rtl/mulc_chk.sv
module mulc_chk #(
  parameter int AW = 18,
  parameter int BW = 18,
  parameter bit A_REG = 1'b1,
  parameter bit B_REG = 1'b1,
  parameter bit P_REG = 1'b1,
  parameter mulc_pkg::bsrc_e B_SRC = mulc_pkg::B_FROM_PORT,
  localparam int PW = AW + BW
) (
  input logic          clk_e,
  input logic          rst_a_e,
  input logic          ce_b_e,
  input logic          rst_b_e,
  input logic          ce_p_e,
  input logic          rst_p_e,
  input logic [AW-1:0] a_op,
  input logic [BW-1:0] b_casc_in,
  input logic [PW-1:0] prod,
  input logic [BW-1:0] b_casc_out
);
  logic armed = 1'b0;
  always_ff @(posedge clk_e) armed <= 1'b1;

  localparam bit CHAIN = (B_SRC == mulc_pkg::B_FROM_CHAIN);

  // R5: product register reset gives zero on the next edge
  p_preg_rst_r5: assert property (@(posedge clk_e) disable iff (!armed)
    (P_REG && rst_p_e) |=> (prod == '0));

  // R4: product register holds while its enable is inactive
  p_preg_hold_r4: assert property (@(posedge clk_e) disable iff (!armed)
    (P_REG && !rst_p_e && !ce_p_e) |=> $stable(prod));

  // R5: B register reset clears the chain output
  p_breg_rst_r5: assert property (@(posedge clk_e) disable iff (!armed)
    (B_REG && rst_b_e) |=> (b_casc_out == '0));

  // R2 / R3: chain input is loaded into the B register and forwarded
  p_breg_chain_r3: assert property (@(posedge clk_e) disable iff (!armed)
    (B_REG && CHAIN && ce_b_e && !rst_b_e) |=> (b_casc_out == $past(b_casc_in)));

  // R10: A reset with no product register gives a zero product on the next edge
  p_areg_rst_r10: assert property (@(posedge clk_e) disable iff (!armed)
    (A_REG && !P_REG && rst_a_e) |=> (prod == '0));

  // R1: zero first operand with no registers in its path gives zero product
  p_no_overflow_r1: assert property (@(posedge clk_e) disable iff (!armed)
    (!A_REG && !P_REG && (a_op == '0)) |-> (prod == '0));
endmodule

bind mul_casc mulc_chk #(
  .AW(AW), .BW(BW), .A_REG(A_REG), .B_REG(B_REG), .P_REG(P_REG), .B_SRC(B_SRC)
) u_chk (
  .clk_e(clk_e), .rst_a_e(rst_a_e), .ce_b_e(ce_b_e), .rst_b_e(rst_b_e),
  .ce_p_e(ce_p_e), .rst_p_e(rst_p_e), .a_op(a_op), .b_casc_in(b_casc_in),
  .prod(prod), .b_casc_out(b_casc_out)
);

// File: tb/test_mul_casc.sv
module test_mul_casc;
  localparam int NCFG = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic signed [17:0] a_op = '0, b_op = '0, b_cin = '0;
  logic cea = 0, rsta = 0, ceb = 0, rstb = 0, cep = 0, rstp = 0;

  logic [35:0] p_o  [NCFG];
  logic [17:0] bc_o [NCFG];
  logic [35:0] p_n;
  logic [17:0] bc_n;

  int n_chk = 0;
  int n_err = 0;
  string phase_tag = "";

  // cfg bits: [0] A reg, [1] B reg, [2] P reg, [3] chain source
  for (genvar c = 0; c < NCFG; c++) begin : g_cfg
    mul_casc #(
      .A_REG(bit'(c & 1)), .B_REG(bit'((c >> 1) & 1)), .P_REG(bit'((c >> 2) & 1)),
      .B_SRC(((c >> 3) & 1) != 0 ? mulc_pkg::B_FROM_CHAIN : mulc_pkg::B_FROM_PORT)
    ) i_mul_casc (
      .clk(clk), .a_op(a_op), .b_op(b_op), .b_casc_in(b_cin),
      .ce_a(cea), .rst_a(rsta), .ce_b(ceb), .rst_b(rstb), .ce_p(cep), .rst_p(rstp),
      .prod(p_o[c]), .b_casc_out(bc_o[c])
    );
  end

  // All controls and the clock inverted; must match config 7
  mul_casc #(
    .INV_CLK(1'b1), .INV_CE_A(1'b1), .INV_RST_A(1'b1), .INV_CE_B(1'b1),
    .INV_RST_B(1'b1), .INV_CE_P(1'b1), .INV_RST_P(1'b1)
  ) i_mul_casc_neg (
    .clk(~clk), .a_op(a_op), .b_op(b_op), .b_casc_in(b_cin),
    .ce_a(~cea), .rst_a(~rsta), .ce_b(~ceb), .rst_b(~rstb), .ce_p(~cep), .rst_p(~rstp),
    .prod(p_n), .b_casc_out(bc_n)
  );

  // Behavioural reference model
  logic signed [17:0] m_a [NCFG];
  logic signed [17:0] m_b [NCFG];
  logic signed [35:0] m_p [NCFG];
  initial for (int c = 0; c < NCFG; c++) begin m_a[c] = 0; m_b[c] = 0; m_p[c] = 0; end

  function automatic logic signed [17:0] m_bused(int c);
    logic signed [17:0] src;
    src = ((c >> 3) & 1) != 0 ? b_cin : b_op;
    return ((c >> 1) & 1) != 0 ? m_b[c] : src;
  endfunction

  function automatic logic signed [35:0] m_mul(int c);
    longint av, bv;
    av = (c & 1) != 0 ? longint'(m_a[c]) : longint'(a_op);
    bv = longint'(m_bused(c));
    return 36'(av * bv);
  endfunction

  function automatic logic signed [35:0] m_prod(int c);
    return ((c >> 2) & 1) != 0 ? m_p[c] : m_mul(c);
  endfunction

  always @(posedge clk) begin
    for (int c = 0; c < NCFG; c++) begin
      if (rsta) m_a[c] <= 0; else if (cea) m_a[c] <= a_op;
      if (rstb) m_b[c] <= 0; else if (ceb) m_b[c] <= ((c >> 3) & 1) != 0 ? b_cin : b_op;
      if (rstp) m_p[c] <= 0; else if (cep) m_p[c] <= m_mul(c);
    end
  end

  task automatic check(string tag, logic [35:0] act, logic [35:0] exp, int c);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s cfg=%0d actual=%0d expected=%0d", tag, c, $signed(act), $signed(exp));
    end
  endtask

  task automatic compare_all();
    string tp, tb;
    for (int c = 0; c < NCFG; c++) begin
      if (phase_tag != "") tp = phase_tag;
      else if ((c & 7) == 0) tp = "R6";
      else if ((c & 4) != 0) tp = "R7";
      else tp = "R10";
      tb = ((c >> 3) & 1) != 0 ? "R2" : "R3";
      check(tp, p_o[c], m_prod(c), c);
      check(tb, 36'($signed(bc_o[c])), 36'(m_bused(c)), c);
    end
    check("R9", p_n, m_prod(7), 7);
    check("R9", 36'($signed(bc_n)), 36'(m_bused(7)), 7);
  endtask

  // Drive at the falling edge, compare shortly after
  task automatic step(logic signed [17:0] a, logic signed [17:0] b, logic signed [17:0] bc,
                      logic ea, logic ra, logic eb, logic rb, logic ep, logic rp);
    @(negedge clk);
    a_op = a; b_op = b; b_cin = bc;
    cea = ea; rsta = ra; ceb = eb; rstb = rb; cep = ep; rstp = rp;
    #1 compare_all();
  endtask

  function automatic logic signed [17:0] rnd18();
    return 18'($urandom);
  endfunction

  initial begin
    #2000000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    // R8: power-up state before any edge
    #5 phase_tag = "R8";
    compare_all();
    check("R8", p_o[7], 36'd0, 7);
    check("R8", 36'(bc_o[15]), 36'd0, 15);

    // R4: loading with enables active, then holding with enables inactive
    phase_tag = "R4";
    step(18'sd1234, -18'sd77, 18'sd5, 1,0,1,0,1,0);
    step(18'sd1234, -18'sd77, 18'sd5, 1,0,1,0,1,0);
    for (int i = 0; i < 20; i++) step(rnd18(), rnd18(), rnd18(), 0,0,0,0,0,0);
    for (int i = 0; i < 20; i++) step(rnd18(), rnd18(), rnd18(), 1,0,1,0,1,0);

    // R5: reset together with enable clears every register
    phase_tag = "R5";
    step(18'sd999, 18'sd999, 18'sd999, 1,1,1,1,1,1);
    step(18'sd999, 18'sd999, 18'sd999, 1,1,1,1,1,1);
    for (int c = 0; c < NCFG; c++) if ((c & 7) == 7) check("R5", p_o[c], 36'd0, c);
    step(18'sd3, 18'sd4, 18'sd5, 0,1,0,1,0,1);
    step(18'sd3, 18'sd4, 18'sd5, 1,0,1,0,1,0);

    // R1: extreme operand values
    phase_tag = "R1";
    step(-18'sd131072, -18'sd131072, -18'sd131072, 1,0,1,0,1,0);
    step(-18'sd131072, -18'sd131072, -18'sd131072, 1,0,1,0,1,0);
    step(-18'sd131072, -18'sd131072, -18'sd131072, 1,0,1,0,1,0);
    check("R1", p_o[7], 36'sd17179869184, 7);
    check("R1", p_o[0], 36'sd17179869184, 0);
    step(18'sd131071, -18'sd131072, -18'sd131072, 1,0,1,0,1,0);
    check("R1", p_o[0], -36'sd17179738112, 0);
    step(18'sd131071, -18'sd131072, -18'sd131072, 1,0,1,0,1,0);
    step(18'sd131071, -18'sd131072, -18'sd131072, 1,0,1,0,1,0);
    check("R1", p_o[15], -36'sd17179738112, 15);

    // R2: operand ports differ; unused one must not matter
    phase_tag = "R2";
    for (int i = 0; i < 30; i++) step(rnd18(), rnd18(), rnd18(), 1,0,1,0,1,0);

    // Mixed random traffic, tags per configuration
    phase_tag = "";
    for (int i = 0; i < 400; i++) begin
      logic [5:0] r;
      r = 6'($urandom);
      step(rnd18(), rnd18(), rnd18(), $urandom_range(0,3) != 0, r[0] & r[1] & r[2],
           $urandom_range(0,3) != 0, r[3] & r[4] & r[5],
           $urandom_range(0,3) != 0, $urandom_range(0,9) == 0);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule